// File: doc/BRIEF.md
# Dual-Mode Flash Block Manager

This block keeps the bookkeeping for a small NAND array in which each erase block can run in dense two-bit mode or in single-bit mode. For every erase block it holds the cell mode, a pending switch to single-bit mode, an erase counter, an accumulated faulty-bit count, a retired flag and one "programmed since erase" mark per logical page. Commands arrive over a valid/ready handshake. Each accepted command is checked against that state and its allowed changes are applied. The block then stays busy for the time the operation would take in the addressed block's mode. At the end it raises a one-cycle done pulse that carries a status code.

A command is either a page read, a page program, a block erase, a fault report or a request to move a block to single-bit mode. A mode request is taken only when the block holds no programmed page, and it takes effect at the next erase. A dense block whose fault count rises above a programmable threshold is flagged for the same switch. A block whose fault count rises above the ECC correction limit is retired. The block also shows the state of the block addressed on `cmd_blk`, including how many pages that block holds.

The controller is a three-state machine. IDLE accepts a command (IDLE→BUSY on accept). BUSY counts down the operation's cycle count (BUSY→DONE when the timer reaches zero). DONE drives the done pulse for one cycle (DONE→IDLE). Busy times come from the clock frequency parameter `CLK_MHZ`:

| Mode | Read | Program | Erase |
|---|---|---|---|
| single-bit | 25 µs | 250 µs | 500 µs |
| two-bit | 50 µs | 900 µs | 3500 µs |

Top module: `fbm_manager`

## Requirements
- R1: After reset every block is in two-bit mode (`view_mlc`=1, `view_pages`=128), with zero erase and fault counts, no pending switch, not retired, and all pages unprogrammed. `cmd_ready` is 1.
- R2: `view_pages` is 128 for a two-bit block and 64 for a single-bit block. A read or program whose page index is at or above that count completes with status 1 (range) and changes nothing.
- R3: A command accepted in IDLE raises `rsp_done` exactly N cycles after the accepting edge, for exactly one cycle. `cmd_ready` stays 0 from the accepting edge until the cycle after the pulse. N is the busy time from the table above times `CLK_MHZ` (cycles per µs) for an accepted read, program or erase. N is 1 for fault reports, mode requests and every refused command.
- R4: An accepted erase (op 2) increments the block's erase counter by one and clears every programmed mark of that block.
- R5: A program (op 1) to a page already programmed since the last erase completes with status 2 (used) and has no effect. A read (op 0) of any in-range page returns status 0.
- R6: A fault report (op 3) adds `cmd_faults` to the block's fault count. When the count exceeds `ECC_LIMIT` the block is retired. Every later command to it, of any op code, completes with status 3 (retired) and changes nothing.
- R7: A fault report that leaves a two-bit block's count above `cfg_down_thr` sets that block's pending switch. A single-bit block is never flagged.
- R8: A mode request (op 4) to a block with any programmed page completes with status 2. On a clean two-bit block it sets the pending switch without changing the mode. On a single-bit block it has no effect. The pending switch makes the next erase leave the block in single-bit mode, and a single-bit block never returns to two-bit mode.
- R9: An erase that performs the switch takes the busy time of the mode in force before the erase.
- R10: Status codes are 0 ok, 1 range, 2 used, 3 retired. Op codes 5 to 7 complete with status 1 on a block that is not retired. Retired outranks every other status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_down_thr | input | FAULT_W | Fault count above which a two-bit block is flagged for switching |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle and accepting |
| cmd_op | input | 3 | Op code: 0 read, 1 program, 2 erase, 3 fault report, 4 to single-bit |
| cmd_blk | input | BLK_W | Addressed erase block; also selects the view outputs |
| cmd_page | input | 7 | Logical page index within the block |
| cmd_faults | input | FAULT_W | Faulty bits reported by a fault report |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_status | output | 2 | Completion status, valid with `rsp_done` |
| view_pages | output | 8 | Page count of the addressed block |
| view_mlc | output | 1 | Addressed block is in two-bit mode |
| view_pending | output | 1 | Addressed block has a pending switch to single-bit mode |
| view_disabled | output | 1 | Addressed block is retired |
| view_erases | output | ERASE_W | Erase counter of the addressed block |
| view_faults | output | FAULT_W | Fault count of the addressed block |

## Verification
The threshold flag and the retirement rule can fire on the same fault report, when one report carries a block from below the downgrade threshold to above the ECC limit. The bench provokes this with a single large report to an untouched two-bit block. It then judges that both `view_pending` and `view_disabled` are set in the cycle after the done pulse. A second collision is a mode request, or a threshold crossing, followed by an erase. Here the mode flip and the erase-time choice meet in one accepted command. The bench expects the two-bit erase time and single-bit mode afterwards.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    typedef enum logic [2:0] {
        OP_READ   = 3'd0,
        OP_PROG   = 3'd1,
        OP_ERASE  = 3'd2,
        OP_FAULT  = 3'd3,
        OP_TO_SLC = 3'd4
    } fbm_op_e;

    typedef enum logic [1:0] {
        RS_OK      = 2'd0,
        RS_RANGE   = 2'd1,
        RS_USED    = 2'd2,
        RS_RETIRED = 2'd3
    } fbm_rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_DONE = 2'd2
    } fbm_state_e;

    // busy time in nanoseconds times MHz, divided down to cycles
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz) / 1000;
    endfunction

endpackage

// File: rtl/fbm_latency.sv
module fbm_latency
    import fbm_pkg::*;
#(
    parameter int CLK_MHZ = 1,
    parameter int CNT_W   = 12
) (
    input  logic [2:0]       op,
    input  logic             mlc,
    input  logic             ok,
    output logic [CNT_W-1:0] cycles
);
    localparam int L_RD_S = ns_to_cycles(25000,   CLK_MHZ);
    localparam int L_PG_S = ns_to_cycles(250000,  CLK_MHZ);
    localparam int L_ER_S = ns_to_cycles(500000,  CLK_MHZ);
    localparam int L_RD_M = ns_to_cycles(50000,   CLK_MHZ);
    localparam int L_PG_M = ns_to_cycles(900000,  CLK_MHZ);
    localparam int L_ER_M = ns_to_cycles(3500000, CLK_MHZ);

    always_comb begin
        cycles = CNT_W'(1);
        if (ok) begin
            case (op)
                OP_READ:  cycles = mlc ? CNT_W'(L_RD_M) : CNT_W'(L_RD_S);
                OP_PROG:  cycles = mlc ? CNT_W'(L_PG_M) : CNT_W'(L_PG_S);
                OP_ERASE: cycles = mlc ? CNT_W'(L_ER_M) : CNT_W'(L_ER_S);
                default:  cycles = CNT_W'(1);
            endcase
        end
    end
endmodule

// File: rtl/fbm_page_map.sv
module fbm_page_map #(
    parameter int NUM_BLOCKS = 4,
    parameter int PAGES      = 128,
    parameter int BW         = 2,
    parameter int PW         = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic          clr_en,
    input  logic [BW-1:0] blk,
    input  logic [PW-1:0] page,
    output logic          prog_bit,
    output logic          blk_clean
);
    logic [PAGES-1:0] rows [NUM_BLOCKS];

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_row
        logic [PAGES-1:0] row_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (blk == BW'(b)) begin
                if (clr_en)      row_q       <= '0;
                else if (set_en) row_q[page] <= 1'b1;
            end
        end
        assign rows[b] = row_q;
    end

    assign prog_bit  = rows[blk][page];
    assign blk_clean = ~|rows[blk];
endmodule

// File: rtl/fbm_blk_state.sv
module fbm_blk_state
    import fbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int BW         = 2,
    parameter int FW         = 8,
    parameter int EW         = 16,
    parameter int ECC_LIMIT  = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic [2:0]    op,
    input  logic [BW-1:0] blk,
    input  logic [FW-1:0] faults_in,
    input  logic [FW-1:0] down_thr,
    output logic          mlc,
    output logic          pend,
    output logic          dis,
    output logic [EW-1:0] erases,
    output logic [FW-1:0] faults
);
    logic          mlc_a  [NUM_BLOCKS];
    logic          pend_a [NUM_BLOCKS];
    logic          dis_a  [NUM_BLOCKS];
    logic [EW-1:0] ers_a  [NUM_BLOCKS];
    logic [FW-1:0] flt_a  [NUM_BLOCKS];

    for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
        logic          mlc_q, pend_q, dis_q;
        logic [EW-1:0] ers_q;
        logic [FW-1:0] flt_q;
        logic [FW:0]   sum;
        logic [FW-1:0] flt_nx;
        logic          hit;

        assign sum    = {1'b0, flt_q} + {1'b0, faults_in};
        assign flt_nx = sum[FW] ? '1 : sum[FW-1:0];
        assign hit    = commit && (blk == BW'(b));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mlc_q  <= 1'b1;
                pend_q <= 1'b0;
                dis_q  <= 1'b0;
                ers_q  <= '0;
                flt_q  <= '0;
            end else if (hit) begin
                case (op)
                    OP_ERASE: begin
                        if (ers_q != '1) ers_q <= ers_q + 1'b1;
                        if (pend_q) begin
                            mlc_q  <= 1'b0;
                            pend_q <= 1'b0;
                        end
                    end
                    OP_FAULT: begin
                        flt_q <= flt_nx;
                        if (flt_nx > FW'(ECC_LIMIT)) dis_q  <= 1'b1;
                        if (mlc_q && (flt_nx > down_thr)) pend_q <= 1'b1;
                    end
                    OP_TO_SLC: begin
                        if (mlc_q) pend_q <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end

        assign mlc_a[b]  = mlc_q;
        assign pend_a[b] = pend_q;
        assign dis_a[b]  = dis_q;
        assign ers_a[b]  = ers_q;
        assign flt_a[b]  = flt_q;
    end

    assign mlc    = mlc_a[blk];
    assign pend   = pend_a[blk];
    assign dis    = dis_a[blk];
    assign erases = ers_a[blk];
    assign faults = flt_a[blk];
endmodule

// File: rtl/fbm_manager.sv
module fbm_manager
    import fbm_pkg::*;
#(
    parameter int NUM_BLOCKS = 4,
    parameter int CLK_MHZ    = 1,
    parameter int ECC_LIMIT  = 40,
    parameter int FAULT_W    = 8,
    parameter int ERASE_W    = 16,
    localparam int SLC_PAGES = 64,
    localparam int MLC_PAGES = 2 * SLC_PAGES,
    localparam int PAGE_W    = $clog2(MLC_PAGES),
    localparam int CNTV_W    = $clog2(MLC_PAGES + 1),
    localparam int BLK_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FAULT_W-1:0] cfg_down_thr,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [2:0]         cmd_op,
    input  logic [BLK_W-1:0]   cmd_blk,
    input  logic [PAGE_W-1:0]  cmd_page,
    input  logic [FAULT_W-1:0] cmd_faults,
    output logic               rsp_done,
    output logic [1:0]         rsp_status,
    output logic [CNTV_W-1:0]  view_pages,
    output logic               view_mlc,
    output logic               view_pending,
    output logic               view_disabled,
    output logic [ERASE_W-1:0] view_erases,
    output logic [FAULT_W-1:0] view_faults
);
    localparam int LAT_MAX = ns_to_cycles(3500000, CLK_MHZ);
    localparam int CNT_W   = $clog2(LAT_MAX + 1);

    fbm_state_e       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, lat;
    fbm_rsp_e         st_dec;
    logic [1:0]       st_q;
    logic             accept, commit, prog_bit, blk_clean, in_range;

    assign accept   = cmd_valid && (state_q == ST_IDLE);
    assign commit   = accept && (st_dec == RS_OK);
    assign in_range = {1'b0, cmd_page} < view_pages;

    fbm_blk_state #(
        .NUM_BLOCKS(NUM_BLOCKS), .BW(BLK_W), .FW(FAULT_W),
        .EW(ERASE_W), .ECC_LIMIT(ECC_LIMIT)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .commit(commit), .op(cmd_op),
        .blk(cmd_blk), .faults_in(cmd_faults), .down_thr(cfg_down_thr),
        .mlc(view_mlc), .pend(view_pending), .dis(view_disabled),
        .erases(view_erases), .faults(view_faults)
    );

    fbm_page_map #(
        .NUM_BLOCKS(NUM_BLOCKS), .PAGES(MLC_PAGES), .BW(BLK_W), .PW(PAGE_W)
    ) u_pages (
        .clk(clk), .rst_n(rst_n),
        .set_en(commit && (cmd_op == OP_PROG)),
        .clr_en(commit && (cmd_op == OP_ERASE)),
        .blk(cmd_blk), .page(cmd_page),
        .prog_bit(prog_bit), .blk_clean(blk_clean)
    );

    fbm_latency #(.CLK_MHZ(CLK_MHZ), .CNT_W(CNT_W)) u_lat (
        .op(cmd_op), .mlc(view_mlc), .ok(st_dec == RS_OK), .cycles(lat)
    );

    assign view_pages = view_mlc ? CNTV_W'(MLC_PAGES) : CNTV_W'(SLC_PAGES);

    // status decode: retirement outranks every other outcome
    always_comb begin
        st_dec = RS_OK;
        if (view_disabled) begin
            st_dec = RS_RETIRED;
        end else begin
            case (cmd_op)
                OP_READ:   st_dec = in_range ? RS_OK : RS_RANGE;
                OP_PROG:   st_dec = !in_range ? RS_RANGE : (prog_bit ? RS_USED : RS_OK);
                OP_ERASE:  st_dec = RS_OK;
                OP_FAULT:  st_dec = RS_OK;
                OP_TO_SLC: st_dec = blk_clean ? RS_OK : RS_USED;
                default:   st_dec = RS_RANGE;
            endcase
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_valid)       state_nx = ST_BUSY;
            ST_BUSY: if (cnt_q == '0)     state_nx = ST_DONE;
            ST_DONE:                      state_nx = ST_IDLE;
            default:                      state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // busy timer and latched status
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            st_q  <= RS_OK;
        end else if (accept) begin
            cnt_q <= lat - 1'b1;
            st_q  <= st_dec;
        end else if (state_q == ST_BUSY && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // outputs
    always_comb begin
        cmd_ready  = 1'b0;
        rsp_done   = 1'b0;
        rsp_status = st_q;
        unique case (state_q)
            ST_IDLE: cmd_ready = 1'b1;
            ST_BUSY: ;
            ST_DONE: rsp_done  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/fbm_checker.sv
module fbm_checker #(
    parameter int BW = 2,
    parameter int EW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [BW-1:0] cmd_blk,
    input logic          rsp_done,
    input logic          view_mlc,
    input logic          view_disabled,
    input logic [EW-1:0] view_erases
);
    assert_busy_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_not_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !cmd_ready);

    assert_retired_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_blk == $past(cmd_blk) && $past(view_disabled)) |-> view_disabled);

    assert_slc_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_blk == $past(cmd_blk) && !$past(view_mlc)) |-> !view_mlc);

    assert_erase_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_blk == $past(cmd_blk)) |->
            (view_erases == $past(view_erases) || view_erases == $past(view_erases) + 1'b1));
endmodule

bind fbm_manager fbm_checker #(.BW(BLK_W), .EW(ERASE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_blk(cmd_blk), .rsp_done(rsp_done), .view_mlc(view_mlc),
    .view_disabled(view_disabled), .view_erases(view_erases)
);

// File: tb/fbm_manager_test.sv
module fbm_manager_test;
    localparam int CLK_PERIOD = 10;
    localparam int NB   = 4;
    localparam int MHZ  = 1;
    localparam int ECC  = 40;
    localparam int BW   = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_down_thr = 8'd10;
    logic       cmd_valid = 1'b0;
    logic       cmd_ready;
    logic [2:0] cmd_op = '0;
    logic [BW-1:0] cmd_blk = '0;
    logic [6:0] cmd_page = '0;
    logic [7:0] cmd_faults = '0;
    logic       rsp_done;
    logic [1:0] rsp_status;
    logic [7:0] view_pages;
    logic       view_mlc, view_pending, view_disabled;
    logic [15:0] view_erases;
    logic [7:0] view_faults;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fbm_manager #(.NUM_BLOCKS(NB), .CLK_MHZ(MHZ), .ECC_LIMIT(ECC)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_down_thr(cfg_down_thr),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_blk(cmd_blk), .cmd_page(cmd_page), .cmd_faults(cmd_faults),
        .rsp_done(rsp_done), .rsp_status(rsp_status), .view_pages(view_pages),
        .view_mlc(view_mlc), .view_pending(view_pending),
        .view_disabled(view_disabled), .view_erases(view_erases),
        .view_faults(view_faults)
    );

    function automatic int exp_lat(input int op, input bit mlc);
        case (op)
            0: return (mlc ? 50   : 25)  * MHZ;
            1: return (mlc ? 900  : 250) * MHZ;
            2: return (mlc ? 3500 : 500) * MHZ;
            default: return 1;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic issue(input int op, input int blk, input int page, input int flt,
                         output int st, output int lat, output bit ready_seen);
        @(negedge clk);
        cmd_op = 3'(op); cmd_blk = BW'(blk); cmd_page = 7'(page);
        cmd_faults = 8'(flt); cmd_valid = 1'b1;
        @(posedge clk);
        #1;
        cmd_valid = 1'b0;
        lat = 0;
        ready_seen = 0;
        while (!rsp_done && lat < 10000) begin
            if (cmd_ready) ready_seen = 1;
            @(posedge clk);
            #1;
            lat++;
        end
        st = rsp_status;
        @(posedge clk);
        #1;
    endtask

    task automatic run(input string req, input int op, input int blk, input int page,
                       input int flt, input int est, input int elat);
        int st, lat;
        bit rs;
        issue(op, blk, page, flt, st, lat, rs);
        chk(req, "status", st, est);
        chk("R3", "latency", lat, elat);
        chk("R3", "ready during busy", rs, 0);
    endtask

    task automatic peek(input int blk);
        @(negedge clk);
        cmd_blk = BW'(blk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state of every block
        for (int b = 0; b < NB; b++) begin
            peek(b);
            chk("R1", "mlc", view_mlc, 1);
            chk("R1", "pages", view_pages, 128);
            chk("R1", "erases", view_erases, 0);
            chk("R1", "faults", view_faults, 0);
            chk("R1", "pending", view_pending, 0);
            chk("R1", "disabled", view_disabled, 0);
        end
        chk("R1", "ready", cmd_ready, 1);

        // R5 programs on block 0 in two-bit mode, then repeats refused
        for (int p = 0; p < 128; p += 8) run("R5", 1, 0, p, 0, 0, exp_lat(1, 1));
        run("R5", 1, 0, 127, 0, 0, exp_lat(1, 1));
        for (int p = 0; p < 128; p += 8) run("R5", 1, 0, p, 0, 2, 1);
        run("R5", 1, 0, 127, 0, 2, 1);
        for (int p = 0; p < 128; p++) run("R5", 0, 0, p, 0, 0, exp_lat(0, 1));

        // R8 mode request on a dirty block refused
        run("R8", 4, 0, 0, 0, 2, 1);
        peek(0);
        chk("R8", "pending after refused", view_pending, 0);

        // R4 erase clears marks and counts
        run("R4", 2, 0, 0, 0, 0, exp_lat(2, 1));
        peek(0);
        chk("R4", "erases", view_erases, 1);
        run("R4", 1, 0, 0, 0, 0, exp_lat(1, 1));
        run("R4", 2, 0, 0, 0, 0, exp_lat(2, 1));
        run("R8", 4, 0, 0, 0, 0, 1);
        peek(0);
        chk("R8", "pending set", view_pending, 1);
        chk("R8", "mode kept", view_mlc, 1);
        chk("R8", "pages kept", view_pages, 128);
        // R9 switch erase takes two-bit time
        run("R9", 2, 0, 0, 0, 0, exp_lat(2, 1));
        peek(0);
        chk("R8", "now single", view_mlc, 0);
        chk("R2", "pages single", view_pages, 64);
        chk("R8", "pending cleared", view_pending, 0);
        chk("R4", "erases", view_erases, 3);

        // R2 range sweep in single-bit mode
        for (int p = 0; p < 128; p++)
            run("R2", 0, 0, p, 0, (p < 64) ? 0 : 1, (p < 64) ? exp_lat(0, 0) : 1);
        run("R5", 1, 0, 5, 0, 0, exp_lat(1, 0));
        run("R5", 1, 0, 5, 0, 2, 1);
        run("R2", 1, 0, 64, 0, 1, 1);
        run("R2", 1, 0, 63, 0, 0, exp_lat(1, 0));
        run("R4", 2, 0, 0, 0, 0, exp_lat(2, 0));
        run("R8", 4, 0, 0, 0, 0, 1);
        peek(0);
        chk("R8", "single no pending", view_pending, 0);
        run("R8", 2, 0, 0, 0, 0, exp_lat(2, 0));
        peek(0);
        chk("R8", "stays single", view_mlc, 0);
        chk("R4", "erases", view_erases, 5);

        // R10 undefined op codes
        for (int op = 5; op < 8; op++) run("R10", op, 3, 0, 0, 1, 1);
        peek(3);
        chk("R10", "blk3 erases", view_erases, 0);
        chk("R10", "blk3 pending", view_pending, 0);

        // R7 / R6 on block 1
        run("R7", 3, 1, 0, 5, 0, 1);
        peek(1);
        chk("R6", "faults", view_faults, 5);
        chk("R7", "pending below", view_pending, 0);
        run("R7", 3, 1, 0, 6, 0, 1);
        peek(1);
        chk("R7", "pending above", view_pending, 1);
        chk("R7", "still two-bit", view_mlc, 1);
        run("R6", 3, 1, 0, 29, 0, 1);
        peek(1);
        chk("R6", "at limit not retired", view_disabled, 0);
        run("R6", 3, 1, 0, 1, 0, 1);
        peek(1);
        chk("R6", "retired", view_disabled, 1);
        chk("R6", "faults", view_faults, 41);
        for (int op = 0; op < 8; op++) run("R6", op, 1, 3, 7, 3, 1);
        peek(1);
        chk("R6", "faults frozen", view_faults, 41);
        chk("R6", "erases frozen", view_erases, 0);
        chk("R6", "mode frozen", view_mlc, 1);

        // same-command collision: threshold and retirement together
        run("R6", 3, 2, 0, 50, 0, 1);
        peek(2);
        chk("R7", "collision pending", view_pending, 1);
        chk("R6", "collision retired", view_disabled, 1);

        // R7 then erase performs the switch on block 3
        @(negedge clk) cfg_down_thr = 8'd3;
        run("R7", 3, 3, 0, 4, 0, 1);
        peek(3);
        chk("R7", "pending blk3", view_pending, 1);
        run("R9", 2, 3, 0, 0, 0, exp_lat(2, 1));
        peek(3);
        chk("R7", "blk3 single", view_mlc, 0);
        chk("R2", "blk3 pages", view_pages, 64);
        chk("R4", "blk3 erases", view_erases, 1);

        // R7 single-bit block never flagged
        run("R7", 3, 0, 0, 50, 0, 1);
        peek(0);
        chk("R7", "single not flagged", view_pending, 0);
        chk("R6", "single retired", view_disabled, 1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule